// File: doc/BRIEF.md
# Single-Precision to Bfloat16 Rounding Converter

This block is a streaming number-format converter placed between a datapath that works in IEEE binary32 and storage or arithmetic that works in bfloat16. In the narrowing direction it takes a 32-bit single-precision word and returns a 16-bit bfloat16 word. The sign is kept. The 8-bit biased exponent (bias 127) is kept. The 23-bit fraction is cut down to 7 stored bits with round-to-nearest, ties-to-even. Signed zeros, subnormals, infinities and NaNs each get explicit treatment. Two flags travel with every result: an overflow flag for a finite value that rounded up to infinity, and an inexact flag for a narrowing that lost nonzero bits.

In the widening direction a bfloat16 word is placed in the upper half of a binary32 word and the lower half is filled with zeros. That conversion is always exact. A direction bit is sampled with each input word. Both directions share one registered output stage with a valid/ready handshake. A result appears one cycle after the input is accepted and is held unchanged while the consumer withholds ready.

Top module: `bf16_cvt`

## Requirements
- R1: While reset is asserted and in the first cycle after release, out_valid is 0 and in_ready is 1.
- R2: An input is accepted on a clock edge where in_valid and in_ready are both 1. The result shows on out_valid/out_data in the following cycle. in_ready equals (not out_valid) or out_ready. While out_valid is 1 and out_ready is 0, out_data, out_ovf and out_inexact stay unchanged.
- R3: With in_dir = 0 (narrow), out_data[15:0] holds the bfloat16 result {sign, exponent[7:0], fraction[6:0]} and out_data[31:16] is zero. The result is rounded to nearest with ties to even on the 16 discarded low bits. Examples: 3F800000h→3F80h, 3F808000h→3F80h, 3F818000h→3F82h, 3EAAAAABh→3EABh.
- R4: A carry out of the kept fraction increments the exponent: 3FFF8000h→4000h. A subnormal input rounds on the same rule, so the largest subnormal 007FFFFFh gives 0080h, the smallest normal.
- R5: A finite input whose rounded magnitude exceeds 7F7Fh gives infinity of the input's sign (7F80h or FF80h) and sets out_ovf. Otherwise out_ovf is 0.
- R6: Signed zeros and infinities pass through exactly: 00000000h→0000h, 80000000h→8000h, 7F800000h→7F80h, FF800000h→FF80h, with both flags clear.
- R7: A NaN input (exponent FFh, nonzero fraction) is not rounded. The output keeps the sign, sets the exponent to FFh, sets fraction bit 6 to 1 and copies input fraction bits 21:16 into output bits 5:0. The result is always a quiet NaN and never infinity, and both flags are clear.
- R8: For a non-NaN narrowing, out_inexact is 1 exactly when input bits 15:0 are not all zero.
- R9: With in_dir = 1 (widen), out_data = {in_data[15:0], 16'h0000} and out_ovf = out_inexact = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Converter can take a word this cycle |
| in_dir | input | 1 | 0 = binary32 to bfloat16, 1 = bfloat16 to binary32 |
| in_data | input | 32 | Binary32 word (narrow) or bfloat16 in bits 15:0 (widen) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Converted word |
| out_ovf | output | 1 | Finite value rounded to infinity |
| out_inexact | output | 1 | Nonzero bits were discarded |

## Verification
Every result is due exactly one clock edge after the edge that accepts its input. in_ready is combinational, so it is due in the same cycle that out_ready changes. The bench drives inputs on the falling edge and samples shortly after it. A behavioural model advances on each rising edge from the same handshake inputs and predicts out_valid, in_ready and the held payload for every cycle. Each cycle's comparison therefore covers both prompt delivery under back-pressure and the stability of a held result.

// File: rtl/bf16_pkg.sv
package bf16_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned KEEP_W = 7;
  localparam int unsigned SGL_W  = 1 + EXP_W + FRAC_W;
  localparam int unsigned HLF_W  = 1 + EXP_W + KEEP_W;

  typedef struct packed {
    logic [SGL_W-1:0] data;
    logic             ovf;
    logic             inexact;
  } cvt_res_t;

  localparam int unsigned RES_W = $bits(cvt_res_t);
endpackage

// File: rtl/bf16_narrow.sv
module bf16_narrow #(
  parameter int unsigned EXP_W  = bf16_pkg::EXP_W,
  parameter int unsigned FRAC_W = bf16_pkg::FRAC_W,
  parameter int unsigned KEEP_W = bf16_pkg::KEEP_W,
  localparam int unsigned SW    = 1 + EXP_W + FRAC_W,
  localparam int unsigned OW    = 1 + EXP_W + KEEP_W
) (
  input  logic [SW-1:0] src,
  output logic [OW-1:0] dst,
  output logic          ovf,
  output logic          inexact
);
  localparam int unsigned DROP = FRAC_W - KEEP_W;
  localparam logic [SW-1:0] HALF_M1 = SW'((64'd1 << (DROP - 1)) - 64'd1);

  logic              sgn;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_all1;
  logic              is_nan;
  logic [DROP-1:0]   tail;
  logic              keep_lsb;
  logic [SW-1:0]     sum;
  logic [OW-2:0]     mag;
  logic [OW-1:0]     nan_word;
  logic              unused_sum;

  assign sgn      = src[SW-1];
  assign expo     = src[SW-2 -: EXP_W];
  assign frac     = src[FRAC_W-1:0];
  assign exp_all1 = &expo;
  assign is_nan   = exp_all1 & (|frac);
  assign tail     = src[DROP-1:0];
  assign keep_lsb = src[DROP];

  // round to nearest even: add half-minus-one plus the kept lsb to the magnitude
  assign sum        = {1'b0, src[SW-2:0]} + HALF_M1 + SW'(keep_lsb);
  assign mag        = sum[SW-2:DROP];
  assign unused_sum = ^{sum[SW-1], sum[DROP-1:0]};

  // quiet NaN: keep sign and upper payload, force the quiet bit
  assign nan_word = {sgn, {EXP_W{1'b1}}, 1'b1, frac[FRAC_W-2 -: KEEP_W-1]};

  always_comb begin
    if (is_nan) begin
      dst     = nan_word;
      ovf     = 1'b0;
      inexact = 1'b0;
    end else begin
      dst     = {sgn, mag};
      ovf     = ~exp_all1 & (&mag[OW-2 -: EXP_W]);
      inexact = |tail;
    end
  end
endmodule

// File: rtl/bf16_widen.sv
module bf16_widen #(
  parameter int unsigned EXP_W  = bf16_pkg::EXP_W,
  parameter int unsigned FRAC_W = bf16_pkg::FRAC_W,
  parameter int unsigned KEEP_W = bf16_pkg::KEEP_W,
  localparam int unsigned SW    = 1 + EXP_W + FRAC_W,
  localparam int unsigned OW    = 1 + EXP_W + KEEP_W
) (
  input  logic [OW-1:0] src,
  output logic [SW-1:0] dst
);
  localparam int unsigned PAD = SW - OW;
  assign dst = {src, {PAD{1'b0}}};
endmodule

// File: rtl/bf16_out_stage.sv
module bf16_out_stage #(
  parameter int unsigned W = bf16_pkg::RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q, dat_d;
  logic         load_en;

  assign up_ready = ~vld_q | dn_ready;
  assign load_en  = up_valid & up_ready;

  always_comb begin
    vld_d = vld_q;
    dat_d = dat_q;
    if (load_en) begin
      vld_d = 1'b1;
      dat_d = up_data;
    end else if (dn_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (load_en) begin
      dat_q <= dat_d;
    end
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;
endmodule

// File: rtl/bf16_cvt.sv
module bf16_cvt
  import bf16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_dir,
  input  logic [SGL_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SGL_W-1:0] out_data,
  output logic             out_ovf,
  output logic             out_inexact
);
  localparam int unsigned PAD = SGL_W - HLF_W;

  logic [HLF_W-1:0] nar_word;
  logic             nar_ovf;
  logic             nar_inx;
  logic [SGL_W-1:0] wid_word;
  cvt_res_t         res_d;
  cvt_res_t         res_q;
  logic [RES_W-1:0] res_q_flat;

  bf16_narrow #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .KEEP_W(KEEP_W)) u_narrow (
    .src     (in_data),
    .dst     (nar_word),
    .ovf     (nar_ovf),
    .inexact (nar_inx)
  );

  bf16_widen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .KEEP_W(KEEP_W)) u_widen (
    .src (in_data[HLF_W-1:0]),
    .dst (wid_word)
  );

  always_comb begin
    if (in_dir) begin
      res_d.data    = wid_word;
      res_d.ovf     = 1'b0;
      res_d.inexact = 1'b0;
    end else begin
      res_d.data    = {{PAD{1'b0}}, nar_word};
      res_d.ovf     = nar_ovf;
      res_d.inexact = nar_inx;
    end
  end

  bf16_out_stage #(.W(RES_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (res_d),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (res_q_flat)
  );

  assign res_q       = cvt_res_t'(res_q_flat);
  assign out_data    = res_q.data;
  assign out_ovf     = res_q.ovf;
  assign out_inexact = res_q.inexact;
endmodule

// File: rtl/bf16_cvt_chk.sv
module bf16_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_dir,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_ovf,
  input logic        out_inexact
);
  logic unused_sign;
  assign unused_sign = in_data[31];

  AST_ACCEPT_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf) && $stable(out_inexact))); // R2

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_dir) |=> (out_data[31:16] == 16'h0000)); // R3

  AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_data[14:0] == 15'h7F80)); // R5

  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_dir && (in_data[30:23] == 8'hFF) && (in_data[22:0] != 23'd0))
      |=> (out_data[14:6] == 9'h1FF && !out_ovf && !out_inexact)); // R7

  AST_WIDEN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_dir) |=> (out_data[15:0] == 16'h0000 && !out_ovf && !out_inexact)); // R9
endmodule

bind bf16_cvt bf16_cvt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_dir      (in_dir),
  .in_data     (in_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_ovf     (out_ovf),
  .out_inexact (out_inexact)
);

// File: tb/bf16_cvt_bench.sv
module bf16_cvt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_dir = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ovf;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_tag = "R3";

  // reference model state
  bit          m_vld = 1'b0;
  logic [31:0] m_data = '0;
  bit          m_ovf = 1'b0;
  bit          m_inx = 1'b0;
  string       m_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  bf16_cvt u_bf16_cvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir(in_dir), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf),
    .out_inexact(out_inexact)
  );

  function automatic void expect_of(input bit dir, input logic [31:0] x,
                                    output logic [31:0] d, output bit o, output bit ix);
    int unsigned e, f, keep, rem, m;
    bit up;
    if (dir) begin
      d = {x[15:0], 16'h0000}; o = 0; ix = 0;
      return;
    end
    e = int'(x[30:23]); f = int'(x[22:0]);
    if (e == 255 && f != 0) begin
      d = {16'h0000, x[31], 8'hFF, 1'b1, x[21:16]}; o = 0; ix = 0;
      return;
    end
    keep = int'(x[30:16]); rem = int'(x[15:0]);
    up = (rem > 32768) || (rem == 32768 && (keep % 2) == 1);
    m = keep + (up ? 1 : 0);
    d = {16'h0000, x[31], m[14:0]};
    o = (e != 255) && (m >= 32640);
    ix = (rem != 0);
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp_v, cycles);
    end
  endtask

  // model advances on each rising edge from the handshake inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld <= 1'b0;
    end else begin
      cycles <= cycles + 1;
      if (in_valid && (!m_vld || out_ready)) begin
        logic [31:0] d; bit o, ix;
        expect_of(in_dir, in_data, d, o, ix);
        m_vld  <= 1'b1;
        m_data <= d;
        m_ovf  <= o;
        m_inx  <= ix;
        m_tag  <= cur_tag;
      end else if (out_ready) begin
        m_vld <= 1'b0;
      end
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R2", "out_valid", 32'(out_valid), 32'(m_vld));
      check("R2", "in_ready", 32'(in_ready), 32'(!m_vld || out_ready));
      if (m_vld) begin
        check(m_tag, "out_data", out_data, m_data);
        check(m_tag, "out_ovf", 32'(out_ovf), 32'(m_ovf));
        check(m_tag, "out_inexact", 32'(out_inexact), 32'(m_inx));
      end
    end
  end

  task automatic send(input bit dir, input logic [31:0] x, input string tag);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_data = x; cur_tag = tag;
    while (1) begin
      #1 acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    check("R1", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check("R1", "out_valid after reset", 32'(out_valid), 32'd0);

    // R3 nearest-even on normals
    send(0, 32'h3F800000, "R3");
    send(0, 32'hC0000000, "R3");
    send(0, 32'h3F808000, "R3");
    send(0, 32'h3F818000, "R3");
    send(0, 32'h3EAAAAAB, "R3");
    send(0, 32'h40490FDB, "R8");
    // R4 carry into exponent, subnormals
    send(0, 32'h3FFF8000, "R4");
    send(0, 32'h007FFFFF, "R4");
    send(0, 32'h00010000, "R4");
    send(0, 32'h00008001, "R4");
    // R5 overflow
    send(0, 32'h7F7FFFFF, "R5");
    send(0, 32'hFF7F8000, "R5");
    send(0, 32'h7F7F7FFF, "R5");
    // R6 zeros and infinities
    send(0, 32'h00000000, "R6");
    send(0, 32'h80000000, "R6");
    send(0, 32'h7F800000, "R6");
    send(0, 32'hFF800000, "R6");
    // R7 NaNs
    send(0, 32'h7FC00001, "R7");
    send(0, 32'h7F800001, "R7");
    send(0, 32'hFF810000, "R7");
    send(0, 32'h7FFFFFFF, "R7");
    // R9 widen
    send(1, 32'h0000C000, "R9");
    send(1, 32'h1234ABCD, "R9");
    idle(3);

    // R2 back-pressure with random traffic
    fork
      begin
        for (int i = 0; i < 400; i++) begin
          @(negedge clk);
          out_ready = ($urandom % 3) != 0;
        end
      end
      begin
        for (int i = 0; i < 300; i++) begin
          logic [31:0] r;
          bit d;
          r = $urandom;
          d = ($urandom % 4) == 0;
          if ((i % 7) == 0) r[30:23] = 8'hFF;
          if ((i % 11) == 0) r[15:0] = 16'h8000;
          send(d, r, d ? "R9" : "R8");
          if ((i % 5) == 0) idle(1);
        end
        idle(1);
      end
    join
    @(negedge clk);
    out_ready = 1'b1;
    idle(4);
    finish_run();
  end

  initial begin
    wait (cycles >= WATCHDOG);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
    finish_run();
  end
endmodule